// File: doc/BRIEF.md
# Shared-Port Serial EEPROM Access Controller

This block lets a host reach a one-bit serial EEPROM through a memory port that other requesters also use. Software writes one control byte. Setting its request bit asks for the shared port. When no other requester is using the port, the controller takes it and raises a ready flag. From then on, three writable bits drive the EEPROM select, clock and data-out pins directly, and a read-only bit shows the level on the data-in pin. Software generates the EEPROM command protocol itself by toggling these bits.

The ready flag has two jobs. The first time it rises it means the grant, and that can take any number of cycles, depending on the port. After the grant, every write that keeps the request set drops ready, and ready rises again after a fixed interval (800 ns by default). Software waits on this interval to pace its clock edges. Writing the request bit as zero gives the port back. Until a grant is held, the pins stay low and data-in reads as zero.

Control byte layout (bit positions are behaviour):
- bit 5: request (read/write)
- bit 4: ready (read-only)
- bit 3: select (read/write)
- bit 2: clock (read/write)
- bit 1: data out (read/write)
- bit 0: data in (read-only)
- bits 7:6: always read as zero

Top module: `seeprom_port_ctl`

## Requirements
- R1: After reset, `rd_data` is 0x00, `port_req` is low and all three EEPROM output pins are low.
- R2: A write with bit 5 set makes `port_req` high from the write's clock edge onward. Bits 3..1 of the written value read back unchanged in `rd_data[3:1]`.
- R3: While `port_busy` is high and no grant is held, the grant is not taken and `rd_data[4]` (ready) stays 0 for as long as busy lasts.
- R4: On the first clock edge at which the request is registered and `port_busy` is low, the grant is taken and ready reads 1 right after that edge, with no pacing delay.
- R5: While granted, a write with bit 5 set clears ready at its clock edge. Ready reads 0 for exactly DELAY_CYC cycles (100 at an 8 ns clock) and reads 1 after the DELAY_CYC-th following edge.
- R6: A write during a pacing interval restarts the interval in full from that write's edge.
- R7: While granted, `ee_cs`, `ee_sk` and `ee_do` follow control bits 3, 2 and 1 from the edge of the write that sets them.
- R8: While no grant is held, `ee_cs`, `ee_sk` and `ee_do` stay low whatever values are stored in bits 3..1.
- R9: `rd_data[0]` shows `ee_di` as sampled at the previous clock edge while granted, and reads 0 while not granted.
- R10: A write with bit 5 clear releases the port at its edge: `port_req`, ready and all three output pins go low.
- R11: `rd_data[7:6]` always read 0. Written values of bits 7, 6, 4 and 0 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Control byte write strobe |
| wr_data | input | 8 | Control byte write value |
| rd_data | output | 8 | Control byte read value |
| port_busy | input | 1 | Shared port is serving another requester |
| port_req | output | 1 | Request for the shared port |
| ee_cs | output | 1 | EEPROM chip select |
| ee_sk | output | 1 | EEPROM serial clock |
| ee_do | output | 1 | Serial data toward the EEPROM |
| ee_di | input | 1 | Serial data from the EEPROM |

## Verification
Each result has a known due time, counted from the clock edge that captures a write or input:
- Stored bits, `port_req`, the output pins and the drop of ready all change on that capturing edge, so the bench samples them at the following falling edge.
- The grant, and the ready it raises, land one edge after the request is registered with the port idle.
- The data-in bit lags `ee_di` by one edge.

For each pacing interval the bench samples ready at the falling edge after DELAY_CYC-1 further edges, where it must still be 0, and again one edge later, where it must be 1. An interval that is off by one cycle in either direction therefore fails a check.

// File: rtl/seeprom_port_pkg.sv
package seeprom_port_pkg;
  // Bit positions of the control byte; software depends on these.
  localparam int unsigned BIT_REQ   = 5;
  localparam int unsigned BIT_RDY   = 4;
  localparam int unsigned BIT_CS    = 3;
  localparam int unsigned BIT_SK    = 2;
  localparam int unsigned BIT_DO    = 1;
  localparam int unsigned BIT_DI    = 0;
  localparam int unsigned CTL_WIDTH = 8;

  // Fields the host can write.
  typedef struct packed {
    logic req;
    logic cs;
    logic sk;
    logic dout;
  } ctl_fields_t;

  // Pin levels toward the EEPROM.
  typedef struct packed {
    logic cs;
    logic sk;
    logic dout;
  } ee_pins_t;
endpackage

// File: rtl/seeprom_arb.sv
// Tracks ownership of the shared port for the EEPROM requester.
module seeprom_arb (
  input  logic clk,
  input  logic rst,
  input  logic req_q,       // registered request bit
  input  logic release_now, // write that clears the request
  input  logic port_busy,
  output logic granted_q,
  output logic granted_n,
  output logic grant_pulse
);
  always_comb begin
    if (release_now) begin
      granted_n = 1'b0;
    end else begin
      granted_n = req_q & (granted_q | ~port_busy);
    end
  end

  assign grant_pulse = granted_n & ~granted_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      granted_q <= 1'b0;
    end else begin
      granted_q <= granted_n;
    end
  end
endmodule

// File: rtl/seeprom_pace_timer.sv
// Owns the ready flag: set on grant, dropped and re-armed by writes.
module seeprom_pace_timer #(
  parameter int unsigned DELAY_CYC = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic grant_pulse,
  input  logic restart,
  input  logic clear,
  output logic ready_q
);
  localparam int unsigned CW = (DELAY_CYC > 1) ? $clog2(DELAY_CYC) : 1;
  localparam logic [CW-1:0] LOAD = CW'(DELAY_CYC - 1);

  logic [CW-1:0] cnt_q;
  logic          run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ready_q <= 1'b0;
      run_q   <= 1'b0;
      cnt_q   <= '0;
    end else if (clear) begin
      ready_q <= 1'b0;
      run_q   <= 1'b0;
      cnt_q   <= '0;
    end else if (grant_pulse) begin
      ready_q <= 1'b1;
      run_q   <= 1'b0;
      cnt_q   <= '0;
    end else if (restart) begin
      ready_q <= 1'b0;
      run_q   <= 1'b1;
      cnt_q   <= LOAD;
    end else if (run_q) begin
      if (cnt_q == '0) begin
        ready_q <= 1'b1;
        run_q   <= 1'b0;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/seeprom_pin_drv.sv
// Registered pin drive, gated by the grant, plus data-in sampling.
module seeprom_pin_drv
  import seeprom_port_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        granted_n,
  input  ctl_fields_t fields_n,
  input  logic        ee_di,
  output ee_pins_t    pins_q,
  output logic        di_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pins_q <= '0;
      di_q   <= 1'b0;
    end else begin
      pins_q.cs   <= granted_n & fields_n.cs;
      pins_q.sk   <= granted_n & fields_n.sk;
      pins_q.dout <= granted_n & fields_n.dout;
      di_q        <= granted_n & ee_di;
    end
  end
endmodule

// File: rtl/seeprom_port_ctl.sv
module seeprom_port_ctl
  import seeprom_port_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_PS = 8000,
  parameter int unsigned PACE_NS       = 800
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [CTL_WIDTH-1:0] wr_data,
  output logic [CTL_WIDTH-1:0] rd_data,
  input  logic                 port_busy,
  output logic                 port_req,
  output logic                 ee_cs,
  output logic                 ee_sk,
  output logic                 ee_do,
  input  logic                 ee_di
);
  // Pacing interval in clock cycles, rounded up.
  localparam int unsigned DELAY_CYC_RAW = (PACE_NS * 1000 + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;
  localparam int unsigned DELAY_CYC     = (DELAY_CYC_RAW < 1) ? 1 : DELAY_CYC_RAW;

  ctl_fields_t fields_q, fields_n;
  ee_pins_t    pins_q;
  logic        granted_q, granted_n, grant_pulse;
  logic        ready_q, di_q;
  logic        release_now, restart;

  always_comb begin
    fields_n = fields_q;
    if (wr_en) begin
      fields_n.req  = wr_data[BIT_REQ];
      fields_n.cs   = wr_data[BIT_CS];
      fields_n.sk   = wr_data[BIT_SK];
      fields_n.dout = wr_data[BIT_DO];
    end
  end

  assign release_now = wr_en & ~wr_data[BIT_REQ];
  assign restart     = wr_en &  wr_data[BIT_REQ] & granted_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      fields_q <= '0;
    end else begin
      fields_q <= fields_n;
    end
  end

  seeprom_arb u_arb (
    .clk         (clk),
    .rst         (rst),
    .req_q       (fields_q.req),
    .release_now (release_now),
    .port_busy   (port_busy),
    .granted_q   (granted_q),
    .granted_n   (granted_n),
    .grant_pulse (grant_pulse)
  );

  seeprom_pace_timer #(.DELAY_CYC(DELAY_CYC)) u_timer (
    .clk         (clk),
    .rst         (rst),
    .grant_pulse (grant_pulse),
    .restart     (restart),
    .clear       (release_now),
    .ready_q     (ready_q)
  );

  seeprom_pin_drv u_pins (
    .clk       (clk),
    .rst       (rst),
    .granted_n (granted_n),
    .fields_n  (fields_n),
    .ee_di     (ee_di),
    .pins_q    (pins_q),
    .di_q      (di_q)
  );

  always_comb begin
    rd_data          = '0;
    rd_data[BIT_REQ] = fields_q.req;
    rd_data[BIT_RDY] = ready_q;
    rd_data[BIT_CS]  = fields_q.cs;
    rd_data[BIT_SK]  = fields_q.sk;
    rd_data[BIT_DO]  = fields_q.dout;
    rd_data[BIT_DI]  = di_q;
  end

  assign port_req = fields_q.req;
  assign ee_cs    = pins_q.cs;
  assign ee_sk    = pins_q.sk;
  assign ee_do    = pins_q.dout;
endmodule

// File: rtl/seeprom_port_chk.sv
module seeprom_port_chk (
  input logic       clk,
  input logic       rst,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic [7:0] rd_data,
  input logic       port_busy,
  input logic       port_req,
  input logic       granted_q,
  input logic       ee_cs,
  input logic       ee_sk,
  input logic       ee_do
);
  // R3: no grant is taken while another requester holds the port
  assert_wait_busy_R3: assert property (@(posedge clk) disable iff (rst)
    (!granted_q && port_busy) |=> !granted_q);

  // R4: ready can only be seen with the request held
  assert_ready_needs_req_R4: assert property (@(posedge clk) disable iff (rst)
    rd_data[4] |-> port_req);

  // R5: a paced write drops ready on the next cycle
  assert_ready_drop_R5: assert property (@(posedge clk) disable iff (rst)
    (granted_q && wr_en && wr_data[5]) |=> !rd_data[4]);

  // R8: pins stay inactive without a grant
  assert_pins_gated_R8: assert property (@(posedge clk) disable iff (rst)
    !granted_q |-> (!ee_cs && !ee_sk && !ee_do));

  // R10: releasing drops grant, ready and pins
  assert_release_R10: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_data[5]) |=> (!granted_q && !rd_data[4] && !ee_cs && !ee_sk && !port_req));

  // R11: upper bits never read as one
  assert_upper_zero_R11: assert property (@(posedge clk) disable iff (rst)
    rd_data[7:6] == 2'b00);
endmodule

bind seeprom_port_ctl seeprom_port_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .wr_en     (wr_en),
  .wr_data   (wr_data),
  .rd_data   (rd_data),
  .port_busy (port_busy),
  .port_req  (port_req),
  .granted_q (granted_q),
  .ee_cs     (ee_cs),
  .ee_sk     (ee_sk),
  .ee_do     (ee_do)
);

// File: tb/sim_seeprom_port_ctl.sv
module sim_seeprom_port_ctl;
  localparam int D = 100; // 800 ns at 8 ns clock

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       port_busy = 1'b0;
  logic       port_req;
  logic       ee_cs, ee_sk, ee_do;
  logic       ee_di = 1'b0;

  int n_vec  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  seeprom_port_ctl u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .port_busy(port_busy), .port_req(port_req),
    .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_do(ee_do), .ee_di(ee_di)
  );

  // {write value, data-in level, expected read, expected {cs,sk,do}}
  localparam logic [19:0] VEC [6] = '{
    {8'h2A, 1'b0, 8'h3A, 3'b101},
    {8'h24, 1'b1, 8'h35, 3'b010},
    {8'h20, 1'b1, 8'h31, 3'b000},
    {8'h2E, 1'b0, 8'h3E, 3'b111},
    {8'h22, 1'b1, 8'h33, 3'b001},
    {8'hE8, 1'b0, 8'h38, 3'b100}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    idle(3);
    rst = 1'b0;
    idle(1);
    // R1
    chk("R1 rd", rd_data, 8'h00);
    chk("R1 pins", {port_req, ee_cs, ee_sk, ee_do}, 4'b0000);

    // R11: bits 7,6,4,0 ignored
    wr(8'hD1);
    chk("R11 ignored bits", rd_data, 8'h00);

    // R2 / R8 / R9 / R3 with port busy
    port_busy = 1'b1;
    ee_di = 1'b1;
    wr(8'h2E);
    chk("R2 port_req", port_req, 1'b1);
    chk("R2 readback", rd_data, 8'h2E);
    chk("R8 pins gated", {ee_cs, ee_sk, ee_do}, 3'b000);
    idle(20);
    chk("R3 ready held low", rd_data[4], 1'b0);
    chk("R9 di zero ungranted", rd_data[0], 1'b0);
    chk("R8 pins still gated", {ee_cs, ee_sk, ee_do}, 3'b000);

    // R4: grant on next edge after busy drops
    port_busy = 1'b0;
    idle(1);
    chk("R4 grant ready", rd_data, 8'h3F);
    chk("R7 pins after grant", {ee_cs, ee_sk, ee_do}, 3'b111);

    // Vector walk: R5 interval, R7 pins, R9 data in, R11
    for (int v = 0; v < 6; v++) begin
      ee_di = VEC[v][11];
      wr(VEC[v][19:12]);
      chk("R7 pins at write edge", {ee_cs, ee_sk, ee_do}, VEC[v][2:0]);
      idle(D - 1);
      chk("R5 ready low before interval", rd_data[4], 1'b0);
      idle(1);
      chk("R5 R9 R11 readback", rd_data, {24'h0, VEC[v][10:3]});
    end

    // R6: restart during interval
    ee_di = 1'b0;
    wr(8'h28);
    idle(50);
    wr(8'h2C);
    idle(D - 1);
    chk("R6 restarted interval low", rd_data[4], 1'b0);
    idle(1);
    chk("R6 restarted interval high", rd_data, 8'h3C);

    // R10: release
    wr(8'h0E);
    chk("R10 release rd", rd_data, 8'h0E);
    chk("R10 release pins", {port_req, ee_cs, ee_sk, ee_do}, 4'b0000);

    // R4: re-request, grant without pacing delay
    wr(8'h20);
    chk("R4 not yet granted", rd_data[4], 1'b0);
    idle(1);
    chk("R4 immediate ready", rd_data, 8'h30);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    for (int c = 0; c < 20000; c++) @(posedge clk);
    if (!done) begin
      n_vec++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end
endmodule